// File: doc/BRIEF.md
# Aligning Floating-Point Adder/Subtractor

This block adds or subtracts two floating-point operands held in unpacked form. Each operand has a two's-complement exponent, a separate sign bit and an unsigned magnitude fraction. The block first settles which operand dominates. If one operand is negligible or zero, the result is the other operand. Otherwise the operand with the smaller exponent is shifted right, one bit per clock, until both exponents agree. The shifted-out bits collect in an extension register, and the first discarded bit position decides an optional round of the shifted operand. The block then forms a magnitude sum or difference and corrects a carry-out. Last, it applies a sign-modifier code.

The result is deliberately left unnormalized. A separate normalizer downstream receives the fraction, the widened exponent, the guard flag and the extension word, and it alone checks the exponent range. A caller drives the operands and pulses `start` while the block is idle, then waits for the one-cycle `done` pulse. The result outputs then hold their values until the next accepted `start`.

The control is a five-state machine. IDLE waits for `start`. From IDLE, a bypass case goes straight to DONE, an equal-exponent case goes to ARITH, and any other case goes to ALIGN. ALIGN shifts once per cycle and leaves for ROUND after the last shift. ROUND conditionally increments the shifted operand and moves to ARITH. ARITH writes the result and moves to DONE. DONE pulses `done` and returns to IDLE.

Top module: `fpalign_addsub`

## Requirements
- R1: After reset, `busy`, `done`, `res_sign`, `guard`, `res_exp`, `res_frac` and `ext` are all zero.
- R2: Let D = a_exp − b_exp, with both exponents taken as signed. If `a_frac` is zero, or D < −FRAC_W (−35 by default), the result is B. That is, res_frac = b_frac and res_exp = b_exp. The result sign is b_sign XOR `sub` before the sign code is applied. Both `guard` and `ext` are 0.
- R3: If R2 does not apply and either `b_frac` is zero or D > FRAC_W, the result is A unchanged: its fraction, its exponent and a_sign before the sign code. Both `guard` and `ext` are 0.
- R4: Otherwise the operands are aligned. When D > 0, B shifts right by D and the result exponent is a_exp. When D < 0, A shifts right by −D and the result exponent is b_exp. When D = 0, nothing shifts and `ext` is 0. For a shift of k, `ext` holds the k discarded bits, with the bit just below the kept LSB in bit FRAC_W−1. In other words, ext = (shifted operand << (FRAC_W−k)) truncated to FRAC_W bits.
- R5: After a shift of k ≥ 1, if `no_round` is 0 and bit FRAC_W−1 of `ext` is 1, the shifted operand is incremented by one. If `no_round` is 1, no increment happens. In both cases `ext` keeps its value.
- R6: The operation is an effective subtraction when a_sign XOR b_sign XOR sub = 1. The smaller aligned magnitude is then subtracted from the larger one. The sign is a_sign when |A| ≥ |B| and the inverse of a_sign otherwise. `guard` is 0.
- R7: In an effective addition with no carry out of bit FRAC_W−1, the sum is the result and `guard` is 0. When a carry occurs, `guard` takes the sum's LSB, the sum shifts right by one and the exponent rises by one. If `no_round` is 0 and `guard` is 1, the shifted sum is then incremented. The sign is a_sign.
- R8: `sign_mode` is applied last on every path: 0 keeps the sign, 1 clears it, 2 sets it and 3 inverts it.
- R9: Counting from the clock edge that samples `start`, `done` rises after 1 cycle for R2/R3, after 2 cycles for D = 0, and after |D|+3 cycles for an alignment of |D| ≥ 1. `done` lasts exactly one cycle. While idle, the result outputs stay constant.
- R10: A `start` that arrives while `busy` is 1 is ignored. The operation in progress finishes with its own result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| sub | input | 1 | 1 = A − B, 0 = A + B |
| no_round | input | 1 | 1 disables alignment and carry rounding |
| sign_mode | input | 2 | Result sign code: 0 keep, 1 clear, 2 set, 3 invert |
| a_exp | input | EXP_W | Operand A exponent, two's complement |
| a_sign | input | 1 | Operand A sign |
| a_frac | input | FRAC_W | Operand A magnitude fraction |
| b_exp | input | EXP_W | Operand B exponent, two's complement |
| b_sign | input | 1 | Operand B sign |
| b_frac | input | FRAC_W | Operand B magnitude fraction |
| busy | output | 1 | Operation in progress (any state but IDLE) |
| done | output | 1 | One-cycle pulse: result outputs are valid |
| res_exp | output | EXP_W+1 | Result exponent, widened two's complement |
| res_sign | output | 1 | Result sign |
| res_frac | output | FRAC_W | Unnormalized result fraction |
| guard | output | 1 | LSB dropped by carry correction |
| ext | output | FRAC_W | Bits shifted out during alignment |

## Verification
Suppose the shift counter loads the wrong value or leaves ALIGN one cycle early or late. Then `done` arrives at the wrong cycle count, and `ext` and `res_frac` show a misaligned bit pattern on the very first operation with a nonzero exponent difference. A wrong effective-operation decision or a faulty magnitude comparison shows up as an inverted result sign, or as a sum where a difference was expected. A faulty carry correction shows up as a wrong guard bit or an exponent that is off by one. All of these are visible when `done` pulses, with no further delay. The sweep runs every exponent difference from just below the negligible limit to just above it. It covers every sign combination, both operations and both rounding settings, so each alignment width and each bypass boundary is exercised.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ALIGN = 3'd1,
        ST_ROUND = 3'd2,
        ST_ARITH = 3'd3,
        ST_DONE  = 3'd4
    } fpadd_state_e;

    typedef enum logic [1:0] {
        SGN_KEEP  = 2'd0,
        SGN_CLEAR = 2'd1,
        SGN_SET   = 2'd2,
        SGN_FLIP  = 2'd3
    } sign_mode_e;

    function automatic logic apply_sign(input logic s, input logic [1:0] m);
        logic r;
        unique case (sign_mode_e'(m))
            SGN_KEEP:  r = s;
            SGN_CLEAR: r = 1'b0;
            SGN_SET:   r = 1'b1;
            SGN_FLIP:  r = ~s;
            default:   r = s;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/fpadd_ctrl.sv
module fpadd_ctrl
    import fpadd_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             bypass,
    input  logic [CNT_W-1:0] shamt,
    output logic             load,
    output logic             shift_en,
    output logic             round_en,
    output logic             arith_en,
    output logic             done,
    output logic             busy
);

    fpadd_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    if (bypass)
                        state_d = ST_DONE;
                    else if (shamt == '0)
                        state_d = ST_ARITH;
                    else
                        state_d = ST_ALIGN;
                end
            end
            ST_ALIGN: begin
                if (cnt_q == CNT_W'(1))
                    state_d = ST_ROUND;
            end
            ST_ROUND: state_d = ST_ARITH;
            ST_ARITH: state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Remaining shift count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= shamt;
        else if (shift_en)
            cnt_q <= cnt_q - CNT_W'(1);
    end

    // Per-state outputs
    always_comb begin
        load     = 1'b0;
        shift_en = 1'b0;
        round_en = 1'b0;
        arith_en = 1'b0;
        done     = 1'b0;
        busy     = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                busy = 1'b0;
                load = start;
            end
            ST_ALIGN: shift_en = 1'b1;
            ST_ROUND: round_en = 1'b1;
            ST_ARITH: arith_en = 1'b1;
            ST_DONE:  done     = 1'b1;
            default:  busy     = 1'b0;
        endcase
    end

endmodule

// File: rtl/fpadd_align.sv
module fpadd_align #(
    parameter int FRAC_W = 35
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [FRAC_W-1:0] a_frac_i,
    input  logic [FRAC_W-1:0] b_frac_i,
    input  logic              shift_a_i,
    input  logic              shift_en,
    input  logic              round_en,
    input  logic              no_round,
    output logic [FRAC_W-1:0] a_frac_o,
    output logic [FRAC_W-1:0] b_frac_o,
    output logic [FRAC_W-1:0] ext_o
);

    logic [FRAC_W-1:0] fa_q, fb_q, ext_q;
    logic              sel_a_q;
    logic [FRAC_W-1:0] mover;
    logic              bump;

    assign mover = sel_a_q ? fa_q : fb_q;
    assign bump  = round_en && !no_round && ext_q[FRAC_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fa_q    <= '0;
            fb_q    <= '0;
            ext_q   <= '0;
            sel_a_q <= 1'b0;
        end else if (load) begin
            fa_q    <= a_frac_i;
            fb_q    <= b_frac_i;
            ext_q   <= '0;
            sel_a_q <= shift_a_i;
        end else if (shift_en) begin
            ext_q <= {mover[0], ext_q[FRAC_W-1:1]};
            if (sel_a_q)
                fa_q <= fa_q >> 1;
            else
                fb_q <= fb_q >> 1;
        end else if (bump) begin
            if (sel_a_q)
                fa_q <= fa_q + FRAC_W'(1);
            else
                fb_q <= fb_q + FRAC_W'(1);
        end
    end

    assign a_frac_o = fa_q;
    assign b_frac_o = fb_q;
    assign ext_o    = ext_q;

endmodule

// File: rtl/fpadd_magop.sv
module fpadd_magop
    import fpadd_pkg::*;
#(
    parameter int FRAC_W = 35,
    parameter int EXP_W  = 18
) (
    input  logic              [FRAC_W-1:0] a_frac,
    input  logic              [FRAC_W-1:0] b_frac,
    input  logic                           a_sign,
    input  logic                           b_sign,
    input  logic                           sub,
    input  logic                           no_round,
    input  logic              [1:0]        sign_mode,
    input  logic signed       [EXP_W:0]    exp_in,
    output logic              [FRAC_W-1:0] frac_out,
    output logic signed       [EXP_W:0]    exp_out,
    output logic                           sign_out,
    output logic                           guard_out
);

    localparam int HI_W = FRAC_W / 2;
    localparam int LO_W = FRAC_W - HI_W;

    logic              eff_sub;
    logic              a_ge_b;
    logic [FRAC_W:0]   sum;
    logic [FRAC_W-1:0] diff_ab, diff_ba, half;
    logic              pre_sign;

    // Magnitude compare: upper word decides unless equal
    generate
        if (HI_W > 0) begin : g_split_cmp
            logic [HI_W-1:0] a_hi, b_hi;
            logic [LO_W-1:0] a_lo, b_lo;
            assign a_hi   = a_frac[FRAC_W-1:LO_W];
            assign b_hi   = b_frac[FRAC_W-1:LO_W];
            assign a_lo   = a_frac[LO_W-1:0];
            assign b_lo   = b_frac[LO_W-1:0];
            assign a_ge_b = (a_hi > b_hi) || ((a_hi == b_hi) && (a_lo >= b_lo));
        end else begin : g_flat_cmp
            assign a_ge_b = (a_frac >= b_frac);
        end
    endgenerate

    assign eff_sub = a_sign ^ b_sign ^ sub;
    assign sum     = {1'b0, a_frac} + {1'b0, b_frac};
    assign diff_ab = a_frac - b_frac;
    assign diff_ba = b_frac - a_frac;
    assign half    = sum[FRAC_W:1];

    always_comb begin
        frac_out  = sum[FRAC_W-1:0];
        exp_out   = exp_in;
        guard_out = 1'b0;
        pre_sign  = a_sign;
        if (eff_sub) begin
            if (a_ge_b) begin
                frac_out = diff_ab;
            end else begin
                frac_out = diff_ba;
                pre_sign = ~a_sign;
            end
        end else if (sum[FRAC_W]) begin
            guard_out = sum[0];
            exp_out   = exp_in + (EXP_W+1)'(1);
            frac_out  = half + FRAC_W'(!no_round && sum[0]);
        end
        sign_out = apply_sign(pre_sign, sign_mode);
    end

endmodule

// File: rtl/fpalign_addsub.sv
module fpalign_addsub
    import fpadd_pkg::*;
#(
    parameter int FRAC_W = 35,
    parameter int EXP_W  = 18
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     sub,
    input  logic                     no_round,
    input  logic [1:0]               sign_mode,
    input  logic [EXP_W-1:0]         a_exp,
    input  logic                     a_sign,
    input  logic [FRAC_W-1:0]        a_frac,
    input  logic [EXP_W-1:0]         b_exp,
    input  logic                     b_sign,
    input  logic [FRAC_W-1:0]        b_frac,
    output logic                     busy,
    output logic                     done,
    output logic signed [EXP_W:0]    res_exp,
    output logic                     res_sign,
    output logic [FRAC_W-1:0]        res_frac,
    output logic                     guard,
    output logic [FRAC_W-1:0]        ext
);

    localparam int CNT_W = $clog2(FRAC_W + 1);
    localparam logic signed [EXP_W:0] SPAN_POS = (EXP_W+1)'(FRAC_W);
    localparam logic signed [EXP_W:0] SPAN_NEG = -SPAN_POS;

    // Classification of incoming operands
    logic signed [EXP_W:0] a_x, b_x, ediff, mag;
    logic                  take_a, take_b, bypass, shift_a;
    logic [CNT_W-1:0]      shamt;
    logic                  unused_mag;

    assign a_x     = {a_exp[EXP_W-1], a_exp};
    assign b_x     = {b_exp[EXP_W-1], b_exp};
    assign ediff   = a_x - b_x;
    assign take_b  = (a_frac == '0) || (ediff < SPAN_NEG);
    assign take_a  = !take_b && ((b_frac == '0) || (ediff > SPAN_POS));
    assign bypass  = take_a || take_b;
    assign shift_a = ediff[EXP_W];
    assign mag     = shift_a ? -ediff : ediff;
    assign shamt   = bypass ? '0 : mag[CNT_W-1:0];
    assign unused_mag = ^mag[EXP_W:CNT_W];

    // Control
    logic load, shift_en, round_en, arith_en;

    fpadd_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .bypass   (bypass),
        .shamt    (shamt),
        .load     (load),
        .shift_en (shift_en),
        .round_en (round_en),
        .arith_en (arith_en),
        .done     (done),
        .busy     (busy)
    );

    // Captured operation attributes
    logic signed [EXP_W:0] exp_q;
    logic                  as_q, bs_q, sub_q, nr_q;
    logic [1:0]            mode_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exp_q  <= '0;
            as_q   <= 1'b0;
            bs_q   <= 1'b0;
            sub_q  <= 1'b0;
            nr_q   <= 1'b0;
            mode_q <= '0;
        end else if (load) begin
            exp_q  <= shift_a ? b_x : a_x;
            as_q   <= a_sign;
            bs_q   <= b_sign;
            sub_q  <= sub;
            nr_q   <= no_round;
            mode_q <= sign_mode;
        end
    end

    // Alignment datapath
    logic [FRAC_W-1:0] al_a, al_b;

    fpadd_align #(.FRAC_W(FRAC_W)) u_align (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .a_frac_i  (a_frac),
        .b_frac_i  (b_frac),
        .shift_a_i (shift_a),
        .shift_en  (shift_en),
        .round_en  (round_en),
        .no_round  (nr_q),
        .a_frac_o  (al_a),
        .b_frac_o  (al_b),
        .ext_o     (ext)
    );

    // Magnitude add/subtract
    logic [FRAC_W-1:0]     mo_frac;
    logic signed [EXP_W:0] mo_exp;
    logic                  mo_sign, mo_guard;

    fpadd_magop #(.FRAC_W(FRAC_W), .EXP_W(EXP_W)) u_magop (
        .a_frac    (al_a),
        .b_frac    (al_b),
        .a_sign    (as_q),
        .b_sign    (bs_q),
        .sub       (sub_q),
        .no_round  (nr_q),
        .sign_mode (mode_q),
        .exp_in    (exp_q),
        .frac_out  (mo_frac),
        .exp_out   (mo_exp),
        .sign_out  (mo_sign),
        .guard_out (mo_guard)
    );

    // Result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_exp  <= '0;
            res_sign <= 1'b0;
            res_frac <= '0;
            guard    <= 1'b0;
        end else if (load && take_b) begin
            res_exp  <= b_x;
            res_sign <= apply_sign(b_sign ^ sub, sign_mode);
            res_frac <= b_frac;
            guard    <= 1'b0;
        end else if (load && take_a) begin
            res_exp  <= a_x;
            res_sign <= apply_sign(a_sign, sign_mode);
            res_frac <= a_frac;
            guard    <= 1'b0;
        end else if (arith_en) begin
            res_exp  <= mo_exp;
            res_sign <= mo_sign;
            res_frac <= mo_frac;
            guard    <= mo_guard;
        end
    end

endmodule

// File: rtl/fpalign_addsub_chk.sv
module fpalign_addsub_chk #(
    parameter int FRAC_W = 35,
    parameter int EXP_W  = 18
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  start,
    input logic                  busy,
    input logic                  done,
    input logic                  guard,
    input logic [FRAC_W-1:0]     res_frac,
    input logic [EXP_W:0]        res_exp,
    input logic [FRAC_W-1:0]     ext
);

    // R9: completion pulse lasts a single cycle
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: results frozen while idle with no request
    p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(res_frac) && $stable(res_exp) &&
                               $stable(guard) && $stable(ext)));

    // R4: extension word starts empty for every accepted operation
    p_ext_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (ext == '0));

    // R7: a set guard means a carry was folded into the top fraction bit
    p_guard_top_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && guard) |-> res_frac[FRAC_W-1]);

    // R10: an operation in flight runs on to completion
    p_no_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

endmodule

bind fpalign_addsub fpalign_addsub_chk #(.FRAC_W(FRAC_W), .EXP_W(EXP_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .guard    (guard),
    .res_frac (res_frac),
    .res_exp  (res_exp),
    .ext      (ext)
);

// File: tb/tb_fpalign_addsub.sv
`timescale 1ns/1ps
module tb_fpalign_addsub;

    localparam int FW = 35;
    localparam int EW = 18;
    localparam longint MASK = 64'h7_FFFF_FFFF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, sub = 1'b0, no_round = 1'b0;
    logic [1:0] sign_mode = '0;
    logic [EW-1:0] a_exp = '0, b_exp = '0;
    logic a_sign = 1'b0, b_sign = 1'b0;
    logic [FW-1:0] a_frac = '0, b_frac = '0;
    logic busy, done, res_sign, guard;
    logic signed [EW:0] res_exp;
    logic [FW-1:0] res_frac, ext;

    int n_vec = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    fpalign_addsub #(.FRAC_W(FW), .EXP_W(EW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .sub(sub), .no_round(no_round),
        .sign_mode(sign_mode), .a_exp(a_exp), .a_sign(a_sign), .a_frac(a_frac),
        .b_exp(b_exp), .b_sign(b_sign), .b_frac(b_frac), .busy(busy), .done(done),
        .res_exp(res_exp), .res_sign(res_sign), .res_frac(res_frac),
        .guard(guard), .ext(ext)
    );

    typedef struct {
        longint frac;
        longint expo;
        bit     sign;
        bit     g;
        longint ext;
        int     lat;
        string  tag;
    } res_t;

    function automatic res_t model(longint ae, bit as_, longint af, longint be, bit bs,
                                   longint bf, bit sb, bit nr, int mode);
        res_t r;
        longint d, k, ma, mb, x, s;
        bit ss;
        r.g = 0; r.ext = 0; ss = 0; r.frac = 0; r.expo = 0; r.lat = 1;
        d = ae - be;
        if (af == 0 || d < -35) begin
            r.frac = bf; r.expo = be; ss = bs ^ sb; r.tag = "R2";
        end else if (bf == 0 || d > 35) begin
            r.frac = af; r.expo = ae; ss = as_; r.tag = "R3";
        end else begin
            k = (d < 0) ? -d : d;
            x = (d < 0) ? af : bf;
            r.expo = (d < 0) ? be : ae;
            if (k != 0) begin
                r.ext = (x << (35 - k)) & MASK;
                x = x >> k;
                if (!nr && ((r.ext >> 34) & 1) == 1) x = x + 1;
            end
            ma = (d < 0) ? x : af;
            mb = (d < 0) ? bf : x;
            if (as_ ^ bs ^ sb) begin
                r.tag = "R6";
                if (ma >= mb) begin r.frac = ma - mb; ss = as_; end
                else begin r.frac = mb - ma; ss = !as_; end
            end else begin
                r.tag = "R4";
                s = ma + mb;
                if (s > MASK) begin
                    r.tag = "R7";
                    r.g = bit'(s & 1);
                    s = s >> 1;
                    r.expo = r.expo + 1;
                    if (!nr && r.g) s = s + 1;
                end
                r.frac = s; ss = as_;
            end
            r.lat = (k == 0) ? 2 : int'(k) + 3;
        end
        case (mode)
            1: ss = 0;
            2: ss = 1;
            3: ss = !ss;
            default: ;
        endcase
        r.sign = ss;
        return r;
    endfunction

    task automatic drive(input longint ae, input bit as_, input longint af,
                         input longint be, input bit bs, input longint bf,
                         input bit sb, input bit nr, input int mode);
        a_exp = EW'(ae); a_sign = as_; a_frac = FW'(af);
        b_exp = EW'(be); b_sign = bs; b_frac = FW'(bf);
        sub = sb; no_round = nr; sign_mode = 2'(mode);
    endtask

    task automatic compare(input res_t e, input string tag, input int lat, input bit chk_lat);
        n_vec++;
        if (longint'(res_exp) != e.expo || res_frac != FW'(e.frac) || res_sign != e.sign ||
            guard != e.g || ext != FW'(e.ext)) begin
            n_bad++;
            $display("FAIL %s: got exp=%0d frac=%h s=%0b g=%0b ext=%h expected exp=%0d frac=%h s=%0b g=%0b ext=%h",
                     tag, res_exp, res_frac, res_sign, guard, ext,
                     e.expo, FW'(e.frac), e.sign, e.g, FW'(e.ext));
        end
        if (chk_lat) begin
            n_vec++;
            if (lat != e.lat) begin
                n_bad++;
                $display("FAIL R9 (%s): latency got %0d expected %0d", tag, lat, e.lat);
            end
        end
    endtask

    task automatic run(input longint ae, input bit as_, input longint af,
                       input longint be, input bit bs, input longint bf,
                       input bit sb, input bit nr, input int mode, input string tag_in);
        res_t e;
        int lat;
        @(negedge clk);
        drive(ae, as_, af, be, bs, bf, sb, nr, mode);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        e = model(ae, as_, af, be, bs, bf, sb, nr, mode);
        compare(e, (tag_in != "") ? tag_in : e.tag, lat, 1'b1);
    endtask

    longint apat [3] = '{64'h4_0000_0001, 64'h7_FFFF_FFFF, 64'h1_2345_6789};
    longint bpat [3] = '{64'h5_5555_5555, 64'h7_FFFF_FFFF, 64'h0_0000_0003};

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish");
        summary();
        $finish;
    end

    initial begin
        int cnt;
        res_t e;
        int lat;
        cnt = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        n_vec++;
        if (busy || done || res_sign || guard || res_exp != '0 || res_frac != '0 || ext != '0) begin
            n_bad++;
            $display("FAIL R1: got busy=%0b done=%0b frac=%h ext=%h expected all zero",
                     busy, done, res_frac, ext);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // Sweep over alignment widths, signs, operation and rounding
        for (int d = -37; d <= 37; d++)
            for (int p = 0; p < 3; p++)
                for (int sb = 0; sb < 2; sb++)
                    for (int sg = 0; sg < 4; sg++)
                        for (int nr = 0; nr < 2; nr++) begin
                            run(-7 + d, sg[1], apat[p], -7, sg[0], bpat[p],
                                sb[0], nr[0], cnt % 4, "");
                            cnt++;
                        end

        // R2 / R3 zero operands and extreme exponents
        run(5, 0, 0, 9, 1, 64'h3_0000_0000, 1, 0, 0, "R2");
        run(5, 1, 64'h2_0000_0000, 9, 0, 0, 0, 0, 0, "R3");
        run(131071, 0, 64'h4_0000_0000, -131072, 0, 64'h4_0000_0000, 0, 0, 0, "R3");
        run(-131072, 0, 64'h4_0000_0000, 131071, 1, 64'h6_0000_0000, 1, 0, 0, "R2");

        // R5: rounding of the aligned operand, enabled and disabled
        run(1, 0, 64'h4_0000_0000, 0, 0, 1, 0, 0, 0, "R5");
        run(1, 0, 64'h4_0000_0000, 0, 0, 1, 0, 1, 0, "R5");

        // R7: carry with odd sum, rounding on and off
        run(3, 0, 64'h7_FFFF_FFFF, 3, 0, 2, 0, 0, 0, "R7");
        run(3, 0, 64'h7_FFFF_FFFF, 3, 0, 2, 0, 1, 0, "R7");

        // R8: every sign code on a negative sum
        for (int m = 0; m < 4; m++)
            run(2, 1, 64'h1_0000_0000, 2, 1, 64'h0_1000_0000, 0, 0, m, "R8");

        // R10: start while busy is ignored
        @(negedge clk);
        drive(30, 0, 64'h4_0000_0000, 10, 0, 64'h7_0000_0000, 0, 0, 0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        drive(0, 1, 64'h1_1111_1111, 0, 1, 64'h2_2222_2222, 1, 1, 3);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        e = model(30, 0, 64'h4_0000_0000, 10, 0, 64'h7_0000_0000, 0, 0, 0);
        compare(e, "R10", 0, 1'b0);
        @(negedge clk);
        // R9: outputs held while idle after completion
        repeat (3) @(negedge clk);
        compare(e, "R9", 0, 1'b0);

        summary();
        $finish;
    end

endmodule